// File: doc/BRIEF.md
# Debug Trace Trigger Controller

This block decides when bus samples from a CPU fetch interface are written into an on-chip trace buffer. Software programs one 8-bit control word through a synchronous write port and reads it back combinationally. Two address comparators watch every valid fetch and feed a trigger qualifier. The qualifier fires either on a plain address match or on a tagged opcode fetch that later reaches execution. A storage sequencer then either opens a fixed-length capture window at the trigger, or runs a circular capture that the trigger closes.

Two inputs restrict the register. A secure-mode input prevents the enable bit from being set. A breakpoint-mode input freezes the whole word against writes. The block drives a trace-write strobe with the buffer slot to write, a wrap flag, an armed status and a triggered status.

Top module: `trc_trig_ctl`

## Requirements
- R1: After reset the control word reads 0x00 and both statuses are low. Read layout: bit 7 enable, bit 6 arm, bit 5 tag select, bit 4 start mode, bit 3 break enable, bits 1:0 capture mode. Bit 2 always reads 0.
- R2: While `bkp_mode_i` is high, a register write leaves the control word unchanged.
- R3: While `secure_i` is high, an accepted write stores enable as 0. For example, a write of 0xFF stores 0x3B.
- R4: Arm is stored as 1 only if the same write also stores enable as 1, so a write of 0x40 stores 0x00. `armed` equals the stored arm bit.
- R5: `trace_wr` is asserted only while enable and arm are both 1, and only in a cycle with `fetch_valid` high.
- R6: With tag select 0, the trigger fires in any valid fetch cycle whose address equals `cmp_a_addr` or `cmp_b_addr`. With tag select 1, a matching fetch only fires if it has `fetch_tag` set and a later `exec_valid` cycle follows. `exec_flush` cancels the pending tag, and an untagged match never fires.
- R7: With start mode 0, every valid fetch is stored while armed, including the trigger cycle. At the edge after the trigger, arm clears and `triggered` goes high.
- R8: `trace_ptr` gives the slot of the current write and advances modulo DEPTH after each write. `trace_wrap` goes high when the pointer passes slot DEPTH-1. An accepted write that stores arm=1 returns both to 0.
- R9: With start mode 1, nothing is stored before the trigger. From the trigger cycle on, exactly DEPTH samples are stored. `triggered` rises at the trigger and stays high after arm clears itself following the last sample.
- R10: Any accepted register write clears `triggered`. A write that stores arm=0 stops storing from the next cycle without setting `triggered`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write data |
| reg_rdata | output | 8 | Control word read data |
| secure_i | input | 1 | Secure mode; blocks setting enable |
| bkp_mode_i | input | 1 | Breakpoint mode; locks the control word |
| cmp_a_addr | input | AW | Comparator A address |
| cmp_b_addr | input | AW | Comparator B address |
| fetch_valid | input | 1 | Valid fetch/bus sample this cycle |
| fetch_addr | input | AW | Fetch address |
| fetch_tag | input | 1 | Fetch is an opcode fetch eligible for tagging |
| exec_valid | input | 1 | The pending tagged opcode executes |
| exec_flush | input | 1 | Pipeline flush; drops the pending tag |
| trace_wr | output | 1 | Trace buffer write strobe |
| trace_ptr | output | PW | Buffer slot of the current write |
| trace_wrap | output | 1 | Pointer has wrapped since arming |
| armed | output | 1 | Arm bit status |
| triggered | output | 1 | Trigger seen since last register write |

## Verification
The bench builds the block with DEPTH=8 and AW=12, with the tagged variant present. The small depth lets ten stores wrap the circular pointer and lets a begin-mode window run out within a handful of fetch cycles. Both the self-disarm and the wrap flag therefore appear next to the trigger and flush sequences, the secure and lock cases, and a software stop.

// File: rtl/trc_pkg.sv
package trc_pkg;

   typedef struct packed {
      logic       en;
      logic       arm;
      logic       tag_sel;
      logic       start_mode;
      logic       brk_en;
      logic       rsvd;
      logic [1:0] cap_mode;
   } trc_ctrl_t;

   localparam int CTRL_W = $bits(trc_ctrl_t);
   localparam int NCMP   = 2;

endpackage

// File: rtl/trc_ctrl_reg.sv
module trc_ctrl_reg
   import trc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              secure,
   input  logic              bkp_lock,
   input  logic              hw_disarm,
   output trc_ctrl_t         ctrl,
   output logic              wr_acc,
   output logic              arm_load
);
   trc_ctrl_t nxt;

   assign wr_acc = wr_en & ~bkp_lock;

   always_comb begin
      nxt      = trc_ctrl_t'(wdata);
      nxt.en   = wdata[7] & ~secure;
      nxt.arm  = wdata[6] & nxt.en;
      nxt.rsvd = 1'b0;
   end

   assign arm_load = wr_acc & nxt.arm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ctrl     <= '0;
      else if (wr_acc)    ctrl     <= nxt;
      else if (hw_disarm) ctrl.arm <= 1'b0;
   end
endmodule

// File: rtl/trc_addr_cmp.sv
module trc_addr_cmp #(
   parameter int AW   = 16,
   parameter int NCMP = 2
)(
   input  logic [NCMP*AW-1:0] ref_addr,
   input  logic [AW-1:0]      addr,
   input  logic               valid,
   output logic               hit
);
   logic [NCMP-1:0] hit_vec;

   for (genvar i = 0; i < NCMP; i++) begin : g_cmp
      assign hit_vec[i] = (ref_addr[i*AW +: AW] == addr);
   end

   assign hit = valid & (|hit_vec);
endmodule

// File: rtl/trc_trig_qual.sv
module trc_trig_qual #(
   parameter bit TAG_EN = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic tag_sel,
   input  logic hit,
   input  logic fetch_tag,
   input  logic exec_valid,
   input  logic exec_flush,
   output logic trig_evt
);
   logic plain_fire;
   logic tag_fire;

   assign plain_fire = active & ~tag_sel & hit;

   if (TAG_EN) begin : g_tag
      logic pending;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                pending <= 1'b0;
         else if (!active)          pending <= 1'b0;
         else if (exec_flush)       pending <= 1'b0;
         else if (hit && fetch_tag) pending <= 1'b1;
         else if (exec_valid)       pending <= 1'b0;
      end
      assign tag_fire = active & tag_sel & pending & exec_valid & ~exec_flush;
   end else begin : g_notag
      logic unused_tag;
      assign unused_tag = fetch_tag ^ exec_valid ^ exec_flush ^ clk ^ rst_n;
      assign tag_fire   = 1'b0;
   end

   assign trig_evt = plain_fire | tag_fire;
endmodule

// File: rtl/trc_store_seq.sv
module trc_store_seq #(
   parameter int DEPTH = 64,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          start_mode,
   input  logic          trig_evt,
   input  logic          fetch_valid,
   input  logic          wr_acc,
   input  logic          arm_load,
   output logic          trace_wr,
   output logic [PW-1:0] ptr,
   output logic          wrap,
   output logic          triggered,
   output logic          hw_disarm
);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic          started;
   logic          window;
   logic          at_last;
   logic [PW-1:0] ptr_nxt;

   if ((1 << PW) == DEPTH) begin : g_pow2
      assign ptr_nxt = ptr + 1'b1;
   end else begin : g_mod
      assign ptr_nxt = at_last ? '0 : ptr + 1'b1;
   end

   assign at_last   = (ptr == LAST);
   assign window    = start_mode ? (started | trig_evt) : 1'b1;
   assign trace_wr  = active & fetch_valid & window;
   assign hw_disarm = active & (start_mode ? (trace_wr & at_last) : trig_evt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr       <= '0;
         wrap      <= 1'b0;
         started   <= 1'b0;
         triggered <= 1'b0;
      end else if (arm_load) begin
         ptr       <= '0;
         wrap      <= 1'b0;
         started   <= 1'b0;
         triggered <= 1'b0;
      end else if (wr_acc) begin
         started   <= 1'b0;
         triggered <= 1'b0;
      end else begin
         if (trace_wr) begin
            ptr <= ptr_nxt;
            if (at_last) wrap <= 1'b1;
         end
         if (active && trig_evt) triggered <= 1'b1;
         if (hw_disarm)                               started <= 1'b0;
         else if (active && trig_evt && start_mode)   started <= 1'b1;
      end
   end
endmodule

// File: rtl/trc_trig_ctl.sv
module trc_trig_ctl
   import trc_pkg::*;
#(
   parameter int AW     = 16,
   parameter int DEPTH  = 64,
   parameter bit TAG_EN = 1'b1,
   localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [7:0]    reg_wdata,
   output logic [7:0]    reg_rdata,
   input  logic          secure_i,
   input  logic          bkp_mode_i,
   input  logic [AW-1:0] cmp_a_addr,
   input  logic [AW-1:0] cmp_b_addr,
   input  logic          fetch_valid,
   input  logic [AW-1:0] fetch_addr,
   input  logic          fetch_tag,
   input  logic          exec_valid,
   input  logic          exec_flush,
   output logic          trace_wr,
   output logic [PW-1:0] trace_ptr,
   output logic          trace_wrap,
   output logic          armed,
   output logic          triggered
);
   if (AW < 1)          begin : g_bad_aw    $error("AW must be at least 1");        end
   if (DEPTH < 2)       begin : g_bad_depth $error("DEPTH must be at least 2");     end
   if (CTRL_W != 8)     begin : g_bad_ctrl  $error("control word must be 8 bits");  end

   trc_ctrl_t ctrl;
   logic      wr_acc;
   logic      arm_load;
   logic      hw_disarm;
   logic      active;
   logic      hit;
   logic      trig_evt;

   trc_ctrl_reg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .wdata    (reg_wdata),
      .secure   (secure_i),
      .bkp_lock (bkp_mode_i),
      .hw_disarm(hw_disarm),
      .ctrl     (ctrl),
      .wr_acc   (wr_acc),
      .arm_load (arm_load)
   );

   assign active = ctrl.en & ctrl.arm;

   trc_addr_cmp #(.AW(AW), .NCMP(NCMP)) u_cmp (
      .ref_addr({cmp_b_addr, cmp_a_addr}),
      .addr    (fetch_addr),
      .valid   (fetch_valid),
      .hit     (hit)
   );

   trc_trig_qual #(.TAG_EN(TAG_EN)) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .tag_sel   (ctrl.tag_sel),
      .hit       (hit),
      .fetch_tag (fetch_tag),
      .exec_valid(exec_valid),
      .exec_flush(exec_flush),
      .trig_evt  (trig_evt)
   );

   trc_store_seq #(.DEPTH(DEPTH)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active),
      .start_mode (ctrl.start_mode),
      .trig_evt   (trig_evt),
      .fetch_valid(fetch_valid),
      .wr_acc     (wr_acc),
      .arm_load   (arm_load),
      .trace_wr   (trace_wr),
      .ptr        (trace_ptr),
      .wrap       (trace_wrap),
      .triggered  (triggered),
      .hw_disarm  (hw_disarm)
   );

   assign reg_rdata = ctrl;
   assign armed     = ctrl.arm;
endmodule

// File: rtl/trc_trig_chk.sv
module trc_trig_chk #(
   parameter int DEPTH = 64,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic          wr_arm_bit,
   input logic [7:0]    reg_rdata,
   input logic          secure_i,
   input logic          bkp_mode_i,
   input logic          trace_wr,
   input logic [PW-1:0] trace_ptr,
   input logic          armed,
   input logic          triggered,
   input logic          trig_evt
);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   p_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && bkp_mode_i |=> reg_rdata[7] == $past(reg_rdata[7]) &&
                               reg_rdata[5:0] == $past(reg_rdata[5:0]));

   p_secure_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && !bkp_mode_i && secure_i |=> !reg_rdata[7]);

   p_arm_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[6] |-> reg_rdata[7]);

   p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !trace_wr);

   p_end_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !reg_rdata[4] && trig_evt && !reg_wr |=> !armed && triggered);

   p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trace_wr && !reg_wr |=>
         trace_ptr == (($past(trace_ptr) == LAST) ? '0 : $past(trace_ptr) + 1'b1));

   p_sw_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && !bkp_mode_i && !wr_arm_bit |=> !armed && !triggered);
endmodule

bind trc_trig_ctl trc_trig_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .wr_arm_bit(reg_wdata[6]),
   .reg_rdata (reg_rdata),
   .secure_i  (secure_i),
   .bkp_mode_i(bkp_mode_i),
   .trace_wr  (trace_wr),
   .trace_ptr (trace_ptr),
   .armed     (armed),
   .triggered (triggered),
   .trig_evt  (trig_evt)
);

// File: tb/sim_trc_trig_ctl.sv
`timescale 1ns/1ps
module sim_trc_trig_ctl;
   localparam int AW    = 12;
   localparam int DEPTH = 8;
   localparam int PW    = $clog2(DEPTH);
   localparam logic [AW-1:0] ADDR_A = 12'h100;
   localparam logic [AW-1:0] ADDR_B = 12'h2A0;
   localparam logic [AW-1:0] ADDR_N = 12'h050;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic          secure_i = 1'b0;
   logic          bkp_mode_i = 1'b0;
   logic          fetch_valid = 1'b0;
   logic [AW-1:0] fetch_addr = '0;
   logic          fetch_tag = 1'b0;
   logic          exec_valid = 1'b0;
   logic          exec_flush = 1'b0;
   logic          trace_wr;
   logic [PW-1:0] trace_ptr;
   logic          trace_wrap;
   logic          armed;
   logic          triggered;

   int checks = 0;
   int errors = 0;
   int m_ptr  = 0;
   int exp_q[$];
   bit done   = 1'b0;

   always #5 clk = ~clk;

   trc_trig_ctl #(.AW(AW), .DEPTH(DEPTH), .TAG_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .secure_i(secure_i), .bkp_mode_i(bkp_mode_i),
      .cmp_a_addr(ADDR_A), .cmp_b_addr(ADDR_B), .fetch_valid(fetch_valid),
      .fetch_addr(fetch_addr), .fetch_tag(fetch_tag), .exec_valid(exec_valid),
      .exec_flush(exec_flush), .trace_wr(trace_wr), .trace_ptr(trace_ptr),
      .trace_wrap(trace_wrap), .armed(armed), .triggered(triggered)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: every write strobe must match the next expected slot
   always @(negedge clk) begin
      if (rst_n && !done && trace_wr) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R5: actual unexpected write at slot %0d expected none", trace_ptr);
         end else begin
            int e;
            e = exp_q.pop_front();
            if (int'(trace_ptr) != e) begin
               errors++;
               $display("FAIL R8: actual slot %0d expected %0d", trace_ptr, e);
            end
         end
      end
   end

   task automatic bus(input logic [AW-1:0] a, input bit fv, input bit tg,
                      input bit ex, input bit fl, input bit exp_wr);
      @(posedge clk); #1;
      reg_wr = 1'b0; fetch_valid = fv; fetch_addr = a; fetch_tag = tg;
      exec_valid = ex; exec_flush = fl;
      if (exp_wr) begin
         exp_q.push_back(m_ptr);
         m_ptr = (m_ptr + 1) % DEPTH;
      end
   endtask

   task automatic idle_settle();
      bus(ADDR_N, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
   endtask

   task automatic wr_reg(input logic [7:0] d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_wdata = d; fetch_valid = 1'b0;
      exec_valid = 1'b0; exec_flush = 1'b0; fetch_tag = 1'b0;
      if (d[7] && d[6] && !secure_i && !bkp_mode_i) m_ptr = 0;
      idle_settle();
   endtask

   task automatic q_empty(input string req);
      chk(req, exp_q.size(), 0);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rdata", reg_rdata, 8'h00);
      chk("R1 armed", armed, 0);
      chk("R1 triggered", triggered, 0);
      chk("R1 wr", trace_wr, 0);

      // R2 lock
      bkp_mode_i = 1'b1;
      wr_reg(8'hC0);
      chk("R2 locked", reg_rdata, 8'h00);
      bkp_mode_i = 1'b0;

      // R3 secure
      secure_i = 1'b1;
      wr_reg(8'hC0);
      chk("R3 C0", reg_rdata, 8'h00);
      wr_reg(8'hFF);
      chk("R3 FF", reg_rdata, 8'h3B);
      secure_i = 1'b0;
      wr_reg(8'h04);
      chk("R1 bit2", reg_rdata, 8'h00);

      // R4 arm needs enable
      wr_reg(8'h40);
      chk("R4 40", reg_rdata, 8'h00);
      wr_reg(8'h80);
      chk("R4 80", reg_rdata, 8'h80);
      chk("R4 armed", armed, 0);
      // R5 enabled but unarmed: no store
      bus(ADDR_A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      idle_settle();
      q_empty("R5 unarmed");

      // R7/R8 end mode with wrap
      wr_reg(8'hC0);
      chk("R4 armed", armed, 1);
      for (int i = 0; i < 10; i++) bus(ADDR_N + AW'(i), 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      bus(ADDR_B, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      idle_settle();
      chk("R7 armed", armed, 0);
      chk("R7 triggered", triggered, 1);
      chk("R8 wrap", trace_wrap, 1);
      chk("R8 ptr", trace_ptr, 3);
      bus(ADDR_N, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      idle_settle();
      q_empty("R7 stop");

      // R9 begin mode, R6 plain trigger on A
      wr_reg(8'hD0);
      chk("R9 rdata", reg_rdata, 8'hD0);
      chk("R10 trig clr", triggered, 0);
      chk("R8 wrap clr", trace_wrap, 0);
      for (int i = 0; i < 3; i++) bus(ADDR_N, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      bus(ADDR_A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      idle_settle();
      chk("R9 trig", triggered, 1);
      chk("R9 armed mid", armed, 1);
      for (int i = 0; i < DEPTH - 1; i++) bus(ADDR_N, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      idle_settle();
      chk("R9 armed end", armed, 0);
      chk("R9 trig held", triggered, 1);
      bus(ADDR_N, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      idle_settle();
      q_empty("R9 window");

      // R6 tagged trigger with flush
      wr_reg(8'hF0);
      bus(ADDR_A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      bus(ADDR_N, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      bus(ADDR_A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      bus(ADDR_N, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      bus(ADDR_N, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      idle_settle();
      chk("R6 flushed", triggered, 0);
      q_empty("R6 flushed");
      bus(ADDR_B, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      bus(ADDR_N, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
      idle_settle();
      chk("R6 tagged", triggered, 1);
      q_empty("R6 tagged");

      // R10 software stop
      wr_reg(8'hC0);
      for (int i = 0; i < 3; i++) bus(ADDR_N, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      wr_reg(8'h80);
      chk("R10 armed", armed, 0);
      chk("R10 triggered", triggered, 0);
      bus(ADDR_A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      idle_settle();
      q_empty("R10 stop");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule